// File: doc/BRIEF.md
# Multi-Event Storage Block Manager

This block manages a segmented analog storage buffer split into `NUM_BLK` blocks that all channels share. A local self-trigger claims one free block to record an event. That block is then held while the manager waits for a system-wide decision. An accept moves the block into a conversion queue. A reject, or a hold timeout that runs out, puts the block back in the free pool. Accepted events are handed to the converter one at a time, in the order they were accepted, through a request/done handshake. Each event carries a tag made of its block index and a timestamp.

Blocks that are not held or queued stay free to record new events. Nearby triggers are therefore still captured while an earlier event waits or is being converted. A mode bit joins every block into one long record. In that mode a single event takes the whole buffer until it has been read out.

The manager drives a write-select vector toward the analog array. It also drives three status flags: buffer exhausted, trigger lost, and joined mode active.

Top module: `mbuf_blk_mgr`

## Requirements
- R1: After reset every block is free, `wr_sel_o` equals 1 (only bit 0 set), and `dig_req_o`, `ovf_o`, `full_mode_o` and `no_free_o` are all 0.
- R2: In split mode, `wr_sel_o` is one-hot and bit i marks block i as the lowest-indexed free block. It is all zero when no block is free. A trigger (`trig_i` high at a clock edge) claims exactly that block.
- R3: A trigger that finds no block to claim is dropped and sets `ovf_o`, which stays 1 until reset. In joined mode, this happens whenever any block is busy. `no_free_o` is 1 whenever no block is free.
- R4: `gacc_i` with `gt_idx_i` naming a held block queues that block, and `dig_req_o` rises at the next edge when the queue was empty. An accept that names a block that is not held has no effect.
- R5: `grej_i` naming a held block frees it at that edge. Accept has priority when both are high.
- R6: A held block that sees neither accept nor reject is freed at the edge `hold_lim_i` cycles after the edge that claimed it. `hold_lim_i` must be nonzero.
- R7: Queued events are presented in acceptance order. `dig_blk_o` is the block index. `dig_ts_o` is the value a free-running counter had at the claiming edge; the counter is 0 after reset and advances by one each cycle.
- R8: While `dig_req_o` is high and `dig_done_i` is low, the request and the tag hold steady. `dig_done_i` with a request pending frees that block at the edge. `dig_done_i` with no request pending has no effect.
- R9: Triggers keep claiming free blocks while another block is held, queued or being converted.
- R10: In joined mode, `wr_sel_o` is all ones when every block is free and zero otherwise. A trigger claims all blocks. Accept and reject act on the whole buffer whatever `gt_idx_i` holds. The tag index is 0, and done frees every block.
- R11: `full_mode_req_i` is copied to `full_mode_o` only at edges where every block is free and no trigger is present. At any other edge the request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_mode_req_i | input | 1 | Requested mode: 1 joins all blocks into one event |
| hold_lim_i | input | HOLD_W | Hold timeout in cycles |
| trig_i | input | 1 | Local self-trigger |
| gacc_i | input | 1 | Global accept |
| grej_i | input | 1 | Global reject |
| gt_idx_i | input | IDX_W | Block named by accept/reject |
| wr_sel_o | output | NUM_BLK | Block(s) that the next trigger records into |
| dig_req_o | output | 1 | Conversion request |
| dig_blk_o | output | IDX_W | Tag: block index |
| dig_ts_o | output | TS_W | Tag: trigger timestamp |
| dig_done_i | input | 1 | Conversion and readout finished |
| full_mode_o | output | 1 | Joined mode active |
| no_free_o | output | 1 | No block free |
| ovf_o | output | 1 | Sticky lost-trigger flag |

## Verification
The bench uses several trigger sequences to tell the allocation rules apart:
- A run of back-to-back triggers checks that blocks are claimed lowest index first.
- A reject in the middle of the run checks that a freed low block is reused before a higher one.
- Accepting blocks out of index order checks that readout follows acceptance order, not index order.
- A trigger during a stalled conversion shows that recording and conversion overlap.
- Filling the buffer and triggering once more separates the exhausted case from a normal claim.

Timeout, ignored accepts and ignored done pulses, a mode request while busy, and a full joined-mode cycle are each probed through `wr_sel_o` and the tags.

// File: rtl/mbuf_pkg.sv
`timescale 1ns/1ps
package mbuf_pkg;
   typedef enum logic [1:0] {
      BLK_FREE   = 2'd0,
      BLK_HELD   = 2'd1,
      BLK_QUEUED = 2'd2
   } blk_st_e;
endpackage

// File: rtl/mbuf_pick.sv
`timescale 1ns/1ps
module mbuf_pick #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] free_i,
   output logic [N-1:0] pick_o
);
   generate
      if (N < 2) begin : g_bad
         $error("mbuf_pick: N must be at least 2");
      end
   endgenerate

   // isolate lowest set bit
   assign pick_o = free_i & (~free_i + N'(1));

   a_r2_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_o) && ((free_i == '0) == (pick_o == '0)));
endmodule

// File: rtl/mbuf_fifo.sv
`timescale 1ns/1ps
module mbuf_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad
         $error("mbuf_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   assign empty_o = (cnt_q == '0);
   assign dout_o  = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push_i) mem[wp_q] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
         if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i |-> cnt_q != CW'(DEPTH));
   a_r8_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/mbuf_slot.sv
`timescale 1ns/1ps
module mbuf_slot
   import mbuf_pkg::*;
#(
   parameter int HOLD_W = 16,
   parameter int TS_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              acc_i,
   input  logic              rej_i,
   input  logic              done_i,
   input  logic [HOLD_W-1:0] hold_lim_i,
   input  logic [TS_W-1:0]   ts_i,
   output blk_st_e           st_o,
   output logic [TS_W-1:0]   ts_o
);
   blk_st_e           st_q;
   logic [HOLD_W-1:0] tmr_q;
   logic              expire;

   assign expire = (tmr_q == hold_lim_i - HOLD_W'(1));
   assign st_o   = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= BLK_FREE;
         tmr_q <= '0;
         ts_o  <= '0;
      end else begin
         case (st_q)
            BLK_FREE: if (alloc_i) begin
               st_q  <= BLK_HELD;
               tmr_q <= '0;
               ts_o  <= ts_i;
            end
            BLK_HELD: begin
               if (acc_i)                 st_q <= BLK_QUEUED;
               else if (rej_i || expire)  st_q <= BLK_FREE;
               tmr_q <= tmr_q + HOLD_W'(1);
            end
            BLK_QUEUED: if (done_i) st_q <= BLK_FREE;
            default: st_q <= BLK_FREE;
         endcase
      end
   end

   a_r2_claim_free_only: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> st_q == BLK_FREE);
   a_r6_timeout_frees: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == BLK_HELD && !acc_i && !rej_i && expire |=> st_q == BLK_FREE);
   a_r4_accept_queues: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == BLK_HELD && acc_i |=> st_q == BLK_QUEUED);
   a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == BLK_QUEUED && done_i |=> st_q == BLK_FREE);
endmodule

// File: rtl/mbuf_blk_mgr.sv
`timescale 1ns/1ps
module mbuf_blk_mgr
   import mbuf_pkg::*;
#(
   parameter int NUM_BLK = 8,
   parameter int TS_W    = 16,
   parameter int HOLD_W  = 16,
   localparam int IDX_W  = $clog2(NUM_BLK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               full_mode_req_i,
   input  logic [HOLD_W-1:0]  hold_lim_i,
   input  logic               trig_i,
   input  logic               gacc_i,
   input  logic               grej_i,
   input  logic [IDX_W-1:0]   gt_idx_i,
   output logic [NUM_BLK-1:0] wr_sel_o,
   output logic               dig_req_o,
   output logic [IDX_W-1:0]   dig_blk_o,
   output logic [TS_W-1:0]    dig_ts_o,
   input  logic               dig_done_i,
   output logic               full_mode_o,
   output logic               no_free_o,
   output logic               ovf_o
);
   localparam int TAG_W = IDX_W + TS_W;

   generate
      if (NUM_BLK < 2 || (1 << IDX_W) != NUM_BLK) begin : g_bad_n
         $error("mbuf_blk_mgr: NUM_BLK must be a power of two >= 2");
      end
      if (TS_W < 1 || HOLD_W < 1) begin : g_bad_w
         $error("mbuf_blk_mgr: widths must be positive");
      end
   endgenerate

   blk_st_e             st   [NUM_BLK];
   logic [TS_W-1:0]     s_ts [NUM_BLK];
   logic [NUM_BLK-1:0]  free_v, held_v, pick;
   logic [NUM_BLK-1:0]  alloc_v, acc_v, rej_v, done_v;
   logic                all_free, any_free, trig_ok;
   logic                mode_q, push, pop, q_empty;
   logic [IDX_W-1:0]    tgt;
   logic [TS_W-1:0]     ts_q;
   logic [TAG_W-1:0]    head;

   assign all_free = &free_v;
   assign any_free = |free_v;
   assign trig_ok  = trig_i && (mode_q ? all_free : any_free);
   assign tgt      = mode_q ? '0 : gt_idx_i;
   assign push     = gacc_i && held_v[tgt];
   assign pop      = dig_done_i && !q_empty;

   mbuf_pick #(.N(NUM_BLK)) u_pick (
      .clk(clk), .rst_n(rst_n), .free_i(free_v), .pick_o(pick)
   );

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_slot
      logic sel;
      assign sel        = mode_q || (tgt == IDX_W'(i));
      assign alloc_v[i] = trig_ok && (mode_q || pick[i]);
      assign acc_v[i]   = gacc_i && sel;
      assign rej_v[i]   = grej_i && sel;
      assign done_v[i]  = pop && (mode_q || (head[TAG_W-1:TS_W] == IDX_W'(i)));
      assign free_v[i]  = (st[i] == BLK_FREE);
      assign held_v[i]  = (st[i] == BLK_HELD);

      mbuf_slot #(.HOLD_W(HOLD_W), .TS_W(TS_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .alloc_i(alloc_v[i]), .acc_i(acc_v[i]), .rej_i(rej_v[i]),
         .done_i(done_v[i]), .hold_lim_i(hold_lim_i), .ts_i(ts_q),
         .st_o(st[i]), .ts_o(s_ts[i])
      );
   end

   mbuf_fifo #(.DEPTH(NUM_BLK), .W(TAG_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(push), .din_i({tgt, s_ts[tgt]}),
      .pop_i(pop), .dout_o(head), .empty_o(q_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_q   <= '0;
         mode_q <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         ts_q <= ts_q + TS_W'(1);
         if (all_free && !trig_i) mode_q <= full_mode_req_i;
         if (trig_i && !trig_ok)  ovf_o  <= 1'b1;
      end
   end

   assign wr_sel_o    = mode_q ? {NUM_BLK{all_free}} : pick;
   assign no_free_o   = !any_free;
   assign full_mode_o = mode_q;
   assign dig_req_o   = !q_empty;
   assign dig_blk_o   = head[TAG_W-1:TS_W];
   assign dig_ts_o    = head[TS_W-1:0];

   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
   a_r8_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
      dig_req_o && !dig_done_i |=> dig_req_o && $stable(dig_blk_o) && $stable(dig_ts_o));
   a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !all_free |=> $stable(full_mode_o));
   a_r10_joined_claim: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q && trig_i && all_free |=> no_free_o && wr_sel_o == '0);
endmodule

// File: tb/mbuf_blk_mgr_tb.sv
`timescale 1ns/1ps
module mbuf_blk_mgr_tb_top;
   localparam int N = 8;
   localparam int IW = 3;
   localparam int TW = 16;
   localparam int HW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic full_mode_req_i = 1'b0;
   logic [HW-1:0] hold_lim_i = 16'd1000;
   logic trig_i = 1'b0, gacc_i = 1'b0, grej_i = 1'b0, dig_done_i = 1'b0;
   logic [IW-1:0] gt_idx_i = '0;
   logic [N-1:0] wr_sel_o;
   logic dig_req_o, full_mode_o, no_free_o, ovf_o;
   logic [IW-1:0] dig_blk_o;
   logic [TW-1:0] dig_ts_o;

   always #2.5 clk = ~clk;

   mbuf_blk_mgr #(.NUM_BLK(N), .TS_W(TW), .HOLD_W(HW)) dut_i (
      .clk(clk), .rst_n(rst_n), .full_mode_req_i(full_mode_req_i),
      .hold_lim_i(hold_lim_i), .trig_i(trig_i), .gacc_i(gacc_i),
      .grej_i(grej_i), .gt_idx_i(gt_idx_i), .wr_sel_o(wr_sel_o),
      .dig_req_o(dig_req_o), .dig_blk_o(dig_blk_o), .dig_ts_o(dig_ts_o),
      .dig_done_i(dig_done_i), .full_mode_o(full_mode_o),
      .no_free_o(no_free_o), .ovf_o(ovf_o)
   );

   int checks = 0, fails = 0;
   int unsigned cyc = 0;
   logic [TW-1:0] blk_ts [N];
   logic [IW-1:0] exp_blk_q [$];
   logic [TW-1:0] exp_ts_q [$];
   bit auto_done = 1'b0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // driver: trigger claims block `blk` (expected by the bench)
   task automatic trig(int blk);
      trig_i = 1'b1;
      if (blk >= 0) blk_ts[blk] = TW'(cyc);
      tick();
      trig_i = 1'b0;
   endtask

   task automatic accept(int idx, int eblk);
      gacc_i = 1'b1; gt_idx_i = IW'(idx);
      exp_blk_q.push_back(IW'(eblk));
      exp_ts_q.push_back(blk_ts[eblk]);
      tick();
      gacc_i = 1'b0;
   endtask

   task automatic reject(int idx);
      grej_i = 1'b1; gt_idx_i = IW'(idx);
      tick();
      grej_i = 1'b0;
   endtask

   // monitor: compares each presented tag against the scoreboard queue
   always @(negedge clk) begin
      if (auto_done) begin
         dig_done_i = 1'b0;
         if (dig_req_o) begin
            if (exp_blk_q.size() == 0) begin
               chk("R7 unexpected request", 1, 0);
            end else begin
               chk("R7 tag block order", 32'(dig_blk_o), 32'(exp_blk_q.pop_front()));
               chk("R7 tag timestamp", 32'(dig_ts_o), 32'(exp_ts_q.pop_front()));
            end
            dig_done_i = 1'b1;
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(5ns * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 wr_sel", 32'(wr_sel_o), 32'h01);
      chk("R1 req", 32'(dig_req_o), 0);
      chk("R1 ovf", 32'(ovf_o), 0);
      chk("R1 mode", 32'(full_mode_o), 0);
      chk("R1 no_free", 32'(no_free_o), 0);

      // R2 lowest first
      trig(0); trig(1); trig(2);
      chk("R2 lowest free after three", 32'(wr_sel_o), 32'h08);
      // R5 reject frees block 1
      reject(1);
      chk("R5 reject frees", 32'(wr_sel_o), 32'h02);
      // R4 accept of non-held block ignored
      gacc_i = 1'b1; gt_idx_i = 3'd4; tick(); gacc_i = 1'b0;
      tick();
      chk("R4 accept of free block ignored", 32'(dig_req_o), 0);
      // R4 accept block 2
      accept(2, 2);
      chk("R4 request raised", 32'(dig_req_o), 1);
      chk("R4 head block", 32'(dig_blk_o), 2);
      tick(3);
      chk("R8 request held without done", 32'(dig_req_o), 1);
      chk("R8 tag steady", 32'(dig_ts_o), 32'(blk_ts[2]));
      // R9 capture during conversion
      trig(1);
      chk("R9 trigger during conversion", 32'(wr_sel_o), 32'h08);
      accept(0, 0);
      auto_done = 1'b1;
      tick(6);
      auto_done = 1'b0; dig_done_i = 1'b0;
      tick();
      chk("R7 queue drained", 32'(dig_req_o), 0);
      chk("R8 done freed blocks", 32'(wr_sel_o), 32'h01);

      // R3 exhaustion
      trig(0);
      for (int b = 2; b < N; b++) trig(b);
      chk("R3 no_free", 32'(no_free_o), 1);
      chk("R2 wr_sel zero when full", 32'(wr_sel_o), 0);
      chk("R3 ovf before", 32'(ovf_o), 0);
      trig(-1);
      chk("R3 ovf set", 32'(ovf_o), 1);
      for (int b = 0; b < N; b++) reject(b);
      chk("R3 ovf sticky", 32'(ovf_o), 1);
      chk("R5 all freed", 32'(wr_sel_o), 32'h01);

      // R8 done with no request ignored
      dig_done_i = 1'b1; tick(); dig_done_i = 1'b0; tick();
      chk("R8 stray done", 32'(dig_req_o), 0);
      chk("R8 stray done state", 32'(wr_sel_o), 32'h01);

      // R6 timeout
      hold_lim_i = 16'd5;
      trig(0);
      tick(4);
      chk("R6 still held", 32'(wr_sel_o), 32'h02);
      tick();
      chk("R6 freed at limit", 32'(wr_sel_o), 32'h01);
      hold_lim_i = 16'd1000;

      // R11 mode request ignored while busy
      trig(0);
      full_mode_req_i = 1'b1;
      tick(3);
      chk("R11 mode ignored while busy", 32'(full_mode_o), 0);
      reject(0);
      tick();
      chk("R11 mode applied when free", 32'(full_mode_o), 1);
      chk("R10 all select", 32'(wr_sel_o), 32'hFF);

      // R10 joined event
      trig(0);
      chk("R10 claims all", 32'(wr_sel_o), 0);
      chk("R10 no_free", 32'(no_free_o), 1);
      accept(5, 0);
      chk("R10 tag index zero", 32'(dig_blk_o), 0);
      auto_done = 1'b1;
      tick(3);
      auto_done = 1'b0; dig_done_i = 1'b0;
      tick();
      chk("R10 done frees all", 32'(wr_sel_o), 32'hFF);
      trig(0);
      reject(3);
      chk("R10 reject frees all", 32'(wr_sel_o), 32'hFF);
      chk("R7 scoreboard empty", 32'(exp_blk_q.size()), 0);
      summary();
   end
endmodule